// File: doc/BRIEF.md
# Serial Flash Command Shift Engine

This block is a register-driven serial master for a configuration flash on a four-wire SPI link. Software writes a 32-bit data word and then an operation word. The operation word gives the direction, a byte count of one to four and a continue flag. The engine then moves those bytes over the link while it reports a busy flag.

Longer flash commands are built from several short operations. A fast read is one example: a 4-byte write holding the command and address, then a 1-byte dummy read, then a number of 4-byte reads. The continue flag keeps chip select asserted from one operation to the next, and only the final operation clears it.

The register port is a plain single-cycle write and combinational read. It has no handshake. Software must poll the busy flag before it issues the next operation.

Top module: `sf_shift_engine`

## Requirements
- R1: After reset, chip select is deasserted (`sf_cs_n`=1), `sf_sck`=0 and `sf_mosi`=0. Both registers read as 0.
- R2: `reg_addr`=0 selects the data register and `reg_addr`=1 selects the operation register. The operation register fields are as follows. Bit 0 is the direction: 1 shifts out, 0 shifts in. Bits 2:1 hold the byte count minus one. Bit 3 is the continue flag. Bit 31 is busy and is read-only. The other bits read as 0. A read of the operation register returns the fields last accepted.
- R3: Busy reads 1 from the cycle after an operation write is accepted. It stays 1 for exactly 8·N·SCK_DIV core cycles, where N is the byte count, and then reads 0.
- R4: An out-shift sends the data register least significant byte first, with each byte MSB first. The link uses SPI mode 0: each bit period is SCK_DIV core cycles, `sf_sck` is low for the first half and high for the second, and `sf_mosi` changes only while `sf_sck` is low.
- R5: An in-shift samples `sf_miso` at each rising `sf_sck` and packs the bytes least significant byte first, with each byte MSB first. The bytes beyond N read as 0. The data register takes the result in the cycle busy falls. `sf_mosi` stays 0 during an in-shift.
- R6: Chip select is asserted throughout a transfer. When busy falls, `sf_cs_n` goes to 1 if continue was clear and stays 0 if continue was set.
- R7: A write to either register while busy is 1 is ignored. The fields, the data word and the transfer in progress are all unchanged.
- R8: A multi-operation command keeps chip select low from its first operation to its last. An example is the fast read 0x0B: a 4-byte write, a 1-byte dummy read and several 4-byte reads, all with continue set except the last.
- R9: `sf_sck` is 0 whenever the engine is not busy, including while chip select is held between operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 1 | 0: data register, 1: operation register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register selected by `reg_addr` (combinational) |
| sf_sck | output | 1 | Serial clock to the flash |
| sf_cs_n | output | 1 | Active-low chip select |
| sf_mosi | output | 1 | Serial data to the flash |
| sf_miso | input | 1 | Serial data from the flash |

## Verification
An operation write is captured at a clock edge, and busy and chip select change at that same edge. Busy must then read 1 for exactly 8·N·SCK_DIV cycles, so the bench counts busy cycles and SCK-high cycles at falling core-clock edges. It checks chip select and the received data word in the first cycle in which busy reads 0. Outgoing bytes are captured by a flash model on each rising SCK. The driver queues the expected bytes before it starts each operation, and the monitor compares each byte as soon as its eighth bit has arrived.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int WORD_BYTES = 4;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_OP   = 1'b1;
  localparam int OP_DIR  = 0;
  localparam int OP_CNT  = 1;
  localparam int OP_CONT = 3;
  localparam int OP_BUSY = 31;

  typedef enum logic [7:0] {
    CMD_PAGE_PROG  = 8'd2,
    CMD_WR_DIS     = 8'd4,
    CMD_RD_STATUS  = 8'd5,
    CMD_WR_EN      = 8'd6,
    CMD_FAST_READ  = 8'd11,
    CMD_SECT_ERASE = 8'd216
  } sf_cmd_e;
endpackage

// File: rtl/sfe_sck_gen.sv
module sfe_sck_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic sck,
  output logic sample_en,
  output logic bit_end
);
  localparam int HALF = DIV / 2;
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else if (start) ph_q <= '0;
    else if (run) ph_q <= (ph_q == PW'(DIV - 1)) ? '0 : ph_q + 1'b1;
  end

  assign sck       = run && (ph_q >= PW'(HALF));
  assign sample_en = run && (ph_q == PW'(HALF - 1));
  assign bit_end   = run && (ph_q == PW'(DIV - 1));

  // R9
  idle_phase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (ph_q == '0));
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter #(
  parameter int WB = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     run,
  input  logic                     dir_out,
  input  logic [$clog2(WB)-1:0]    last_byte,
  input  logic [WB*8-1:0]          tx_word,
  input  logic                     sample_en,
  input  logic                     bit_end,
  input  logic                     miso,
  output logic                     mosi,
  output logic                     xfer_done,
  output logic [WB*8-1:0]          rx_word
);
  localparam int BW = $clog2(WB * 8);

  logic [BW-1:0] bit_q;
  logic [BW-1:0] idx;
  logic          last_bit;

  assign idx       = {bit_q[BW-1:3], ~bit_q[2:0]};
  assign last_bit  = (bit_q == {last_byte, 3'b111});
  assign xfer_done = bit_end && last_bit;
  assign mosi      = run && dir_out && tx_word[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      rx_word <= '0;
    end else if (start) begin
      bit_q   <= '0;
      rx_word <= '0;
    end else begin
      if (bit_end && !last_bit) bit_q <= bit_q + 1'b1;
      if (sample_en && !dir_out) rx_word[idx] <= miso;
    end
  end

  // R3
  bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (bit_q <= {last_byte, 3'b111}));
endmodule

// File: rtl/sf_shift_engine.sv
module sf_shift_engine #(
  parameter int SCK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sf_sck,
  output logic        sf_cs_n,
  output logic        sf_mosi,
  input  logic        sf_miso
);
  import sfe_pkg::*;
  localparam int CW = $clog2(WORD_BYTES);

  logic          busy_q, dir_q, cont_q;
  logic [CW-1:0] cnt_q;
  logic [31:0]   data_q;
  logic          op_wr, accept, data_wr;
  logic          sample_en, bit_end, xfer_done;
  logic [31:0]   rx_word;

  assign op_wr   = reg_we && (reg_addr == ADDR_OP);
  assign accept  = op_wr && !busy_q;
  assign data_wr = reg_we && (reg_addr == ADDR_DATA) && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      dir_q   <= 1'b0;
      cont_q  <= 1'b0;
      cnt_q   <= '0;
      data_q  <= '0;
      sf_cs_n <= 1'b1;
    end else begin
      if (accept) begin
        dir_q   <= reg_wdata[OP_DIR];
        cnt_q   <= reg_wdata[OP_CNT +: CW];
        cont_q  <= reg_wdata[OP_CONT];
        busy_q  <= 1'b1;
        sf_cs_n <= 1'b0;
      end
      if (data_wr) data_q <= reg_wdata;
      if (xfer_done) begin
        busy_q  <= 1'b0;
        sf_cs_n <= !cont_q;
        if (!dir_q) data_q <= rx_word;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_OP) begin
      reg_rdata[OP_BUSY]       = busy_q;
      reg_rdata[OP_CONT]       = cont_q;
      reg_rdata[OP_CNT +: CW]  = cnt_q;
      reg_rdata[OP_DIR]        = dir_q;
    end else begin
      reg_rdata = data_q;
    end
  end

  sfe_sck_gen #(.DIV(SCK_DIV)) u_sck (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(busy_q),
    .sck(sf_sck), .sample_en(sample_en), .bit_end(bit_end)
  );

  sfe_shifter #(.WB(WORD_BYTES)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(busy_q),
    .dir_out(dir_q), .last_byte(cnt_q), .tx_word(data_q),
    .sample_en(sample_en), .bit_end(bit_end), .miso(sf_miso),
    .mosi(sf_mosi), .xfer_done(xfer_done), .rx_word(rx_word)
  );

  // R6
  cs_held_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !sf_cs_n);
  // R6
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (sf_cs_n == !cont_q));
  // R7
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && busy_q && !xfer_done) |=> $stable({dir_q, cnt_q, cont_q, data_q}));
  // R9
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sf_sck);
  // R5
  read_mosi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !dir_q) |-> !sf_mosi);
endmodule

// File: tb/sf_shift_engine_bench.sv
module sf_shift_engine_bench;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sf_sck, sf_cs_n, sf_mosi, sf_miso;

  always #2 clk = ~clk;

  sf_shift_engine #(.SCK_DIV(DIV)) u_sf_shift_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sf_sck(sf_sck),
    .sf_cs_n(sf_cs_n), .sf_mosi(sf_mosi), .sf_miso(sf_miso)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard of outgoing bytes
  logic [7:0] exp_q[$];
  bit         is_wr = 1'b1;
  logic [7:0] mon_sh = '0;
  int         mon_n = 0;

  always @(posedge sf_sck) begin
    mon_sh = {mon_sh[6:0], sf_mosi};
    mon_n++;
    if (mon_n == 8) begin
      mon_n = 0;
      if (!is_wr) chk(mon_sh == 8'h00, "R5 mosi quiet in read", {24'b0, mon_sh}, 32'h0);
      else if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", {24'b0, mon_sh}, 32'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(mon_sh == e, "R4 mosi byte", {24'b0, mon_sh}, {24'b0, e});
      end
    end
  end

  // flash model: drives data MSB first, LSB byte first, changes on falling SCK
  logic [31:0] sl_word = '0;
  int          sl_cnt = 0;
  int          sl_base = 0;
  logic [4:0]  sl_i;
  always @(negedge sf_sck) if (!is_wr) sl_cnt++;
  assign sl_i    = 5'((sl_cnt - sl_base) % 32);
  assign sf_miso = sl_word[{sl_i[4:3], ~sl_i[2:0]}];

  int cs_rises = 0;
  always @(posedge sf_cs_n) cs_rises++;

  task automatic wreg(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output int bc, output int hi, output bit csbad);
    bc = 0; hi = 0; csbad = 1'b0;
    reg_addr = 1'b1;
    for (int g = 0; g < 2000; g++) begin
      #1;
      if (!reg_rdata[31]) break;
      bc++;
      if (sf_sck) hi++;
      if (sf_cs_n) csbad = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic run_op(input bit dir, input int n, input bit cont, input logic [31:0] word);
    int bc, hi; bit csbad;
    logic [31:0] v, expw, opw;
    opw = {28'b0, cont, 2'(n - 1), dir};
    if (dir) begin
      is_wr = 1'b1;
      for (int i = 0; i < n; i++) exp_q.push_back(word[8*i +: 8]);
      wreg(1'b0, word);
    end else begin
      is_wr = 1'b0;
      sl_word = word;
      sl_base = sl_cnt;
    end
    wreg(1'b1, opw);
    wait_idle(bc, hi, csbad);
    chk(bc == 8 * n * DIV, "R3 busy cycles", bc, 8 * n * DIV);
    chk(hi == 4 * n * DIV, "R4 sck high cycles", hi, 4 * n * DIV);
    chk(!csbad, "R6 cs low while busy", {31'b0, csbad}, 32'h0);
    chk(sf_cs_n == !cont, "R6 cs after op", {31'b0, sf_cs_n}, {31'b0, !cont});
    chk(sf_sck == 1'b0, "R9 sck idle", {31'b0, sf_sck}, 32'h0);
    rreg(1'b1, v);
    chk(v == opw, "R2 op readback", v, opw);
    if (!dir) begin
      expw = (n == 4) ? word : (word & ((32'h1 << (8 * n)) - 1));
      rreg(1'b0, v);
      chk(v == expw, "R5 received word", v, expw);
    end
  endtask

  initial begin
    #400000;
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    int bc, hi; bit csbad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(sf_cs_n == 1'b1 && sf_sck == 1'b0 && sf_mosi == 1'b0, "R1 pins after reset",
        {29'b0, sf_cs_n, sf_sck, sf_mosi}, 32'h4);
    rreg(1'b0, v); chk(v == 32'h0, "R1 data after reset", v, 32'h0);
    rreg(1'b1, v); chk(v == 32'h0, "R1 op after reset", v, 32'h0);

    // status read: 1-byte command with continue, then 1-byte read
    run_op(1'b1, 1, 1'b1, {24'h0, sfe_pkg::CMD_RD_STATUS});
    chk(sf_sck == 1'b0 && sf_cs_n == 1'b0, "R9 idle with cs held", {30'b0, sf_sck, sf_cs_n}, 32'h0);
    run_op(1'b0, 1, 1'b0, 32'hFFFF_FFA5);

    // 2- and 3-byte writes without continue
    run_op(1'b1, 2, 1'b0, 32'h1234_C3F0);
    run_op(1'b1, 3, 1'b0, 32'hAA81_7E01);

    // fast-read command spanning four operations
    base = cs_rises;
    run_op(1'b1, 4, 1'b1, {8'h40, 8'h12, 8'h07, sfe_pkg::CMD_FAST_READ});
    run_op(1'b0, 1, 1'b1, 32'h0000_005A);
    run_op(1'b0, 4, 1'b1, 32'hCAFE_F00D);
    chk(cs_rises == base, "R8 cs held across command", cs_rises, base);
    run_op(1'b0, 4, 1'b0, 32'h1234_5678);
    chk(cs_rises == base + 1, "R8 cs released at end", cs_rises, base + 1);

    // writes while busy are ignored
    is_wr = 1'b1;
    for (int i = 0; i < 4; i++) exp_q.push_back(8'h11 * 8'(i + 1));
    wreg(1'b0, 32'h4433_2211);
    wreg(1'b1, 32'h0000_0007);
    wreg(1'b1, 32'h0000_0008);
    wreg(1'b0, 32'hDEAD_BEEF);
    rreg(1'b1, v);
    chk(v[31] == 1'b1, "R7 still busy after ignored writes", {31'b0, v[31]}, 32'h1);
    wait_idle(bc, hi, csbad);
    chk(sf_cs_n == 1'b1, "R7 cs after undisturbed op", {31'b0, sf_cs_n}, 32'h1);
    rreg(1'b1, v); chk(v == 32'h7, "R7 op fields kept", v, 32'h7);
    rreg(1'b0, v); chk(v == 32'h4433_2211, "R7 data kept", v, 32'h4433_2211);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all bytes sent", exp_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule